// File: doc/BRIEF.md
# Comma Detect Word Aligner

This block sits behind a deserializer whose 10-bit parallel words have no known character boundary. Each cycle that a raw word is valid, it places the previous raw word in front of the current one and examines all ten possible starting positions of a 10-bit character in that 20-bit span. It looks for the comma whose first seven received bits are `0011111`. When framing is enabled and such a comma appears, the block moves its word boundary to that position. It emits the comma as a framed word and raises a one-cycle comma-detect pulse with it.

When framing is disabled, no search takes place. Words keep flowing at whatever boundary was last in force, so software can freeze the framing once the link is up. Received bit order is MSB first: bit 9 of a raw word arrived before bit 0, and the previous word precedes the current one. A candidate character at offset k is therefore bits `[19-k : 10-k]` of `{previous, current}`. Each framed word appears on the output one clock after the raw word that completes it.

Top module: `comma_word_aligner`

## Requirements
- R1: While reset is held low at a clock edge and on the cycle after it, `out_valid`, `comma_det` and `locked` are 0. The boundary offset is 0.
- R2: A comma is a 10-bit character whose bits 9 down to 3 equal `0011111`. Bits 2 down to 0 take any value.
- R3: The inverted form, bits 9 down to 3 equal to `1100000`, never raises `comma_det` and never moves the boundary.
- R4: With `align_en` high, a comma at any offset k from 0 to 9 of `{previous, current}` is output on the next cycle. That output word equals bits `[19-k:10-k]` of the span, and `comma_det` is 1 on the same cycle.
- R5: After a comma is found at offset k, every later valid word is output as bits `[19-k:10-k]` of `{previous, current}`. This holds until another comma moves the boundary.
- R6: With `align_en` low, a comma at a different offset does not move the boundary, and `comma_det` stays 0.
- R7: `comma_det` is 0 on every cycle that follows a cycle with `align_en` low. The change of mode therefore shows within one word time, below the three-word limit.
- R8: `out_valid` equals `raw_valid` delayed by one clock. On a cycle without a valid input, `comma_det` is 0 on the next cycle and `out_word` holds its value.
- R9: `locked` rises together with the first `comma_det` pulse after reset and then stays 1 until reset.
- R10: When commas match at more than one offset in the same span, the lowest offset is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_word | input | 10 | Unaligned word from the deserializer, bit 9 received first |
| raw_valid | input | 1 | `raw_word` carries a new word this cycle |
| align_en | input | 1 | 1: search for commas and re-frame; 0: keep the current boundary |
| out_word | output | 10 | Framed word |
| out_valid | output | 1 | `out_word` is new this cycle |
| comma_det | output | 1 | One-cycle pulse marking a framed comma |
| locked | output | 1 | A comma has set the boundary since reset |

## Verification
The assertions assume that `raw_valid` and `align_en` are stable across each rising edge and that reset lasts at least one edge. They also assume that a comma pulse is produced only on valid cycles, so they relate `comma_det` to `out_valid` and to the previous value of `align_en`. The stimulus drives every input on the falling edge. It builds each span from an alternating `1010…` filler that cannot contain five consecutive ones. As a result, the only comma in a span is the one the bench inserts at a chosen offset, or two commas placed deliberately for the priority case.

// File: rtl/cwa_pkg.sv
// Shared constants for the comma word aligner.
// Assumes 8b/10b characters, MSB received first.
package cwa_pkg;
    localparam int CWA_WORD_W  = 10;
    localparam int CWA_PAT_LEN = 7;
    localparam logic [CWA_PAT_LEN-1:0] CWA_COMMA = 7'b0011111;
endpackage

// File: rtl/cwa_comma_scan.sv
// Tests every bit offset of a two-word span for the comma prefix in one cycle.
// The lowest matching offset wins. Assumes pair[2*WORD_W-1] is the oldest bit.
module cwa_comma_scan #(
    parameter int WORD_W = cwa_pkg::CWA_WORD_W,
    parameter int PAT_LEN = cwa_pkg::CWA_PAT_LEN,
    parameter logic [PAT_LEN-1:0] PATTERN = cwa_pkg::CWA_COMMA,
    localparam int OFF_W = $clog2(WORD_W)
) (
    input  logic [2*WORD_W-1:0] pair,
    output logic                hit,
    output logic [OFF_W-1:0]    hit_off
);
    logic [WORD_W-1:0] match;

    // One comparator per candidate offset.
    for (genvar k = 0; k < WORD_W; k++) begin : g_off
        assign match[k] = (pair[2*WORD_W-1-k -: PAT_LEN] == PATTERN);
    end

    // Priority encode, lowest offset last so it overrides the others.
    always_comb begin
        hit     = |match;
        hit_off = '0;
        for (int k = WORD_W-1; k >= 0; k--) begin
            if (match[k]) hit_off = OFF_W'(k);
        end
    end
endmodule

// File: rtl/cwa_window_sel.sv
// Picks the WORD_W-bit character starting at offset off from the oldest bit of pair.
// Assumes off < WORD_W.
module cwa_window_sel #(
    parameter int WORD_W = cwa_pkg::CWA_WORD_W,
    localparam int OFF_W = $clog2(WORD_W)
) (
    input  logic [2*WORD_W-1:0] pair,
    input  logic [OFF_W-1:0]    off,
    output logic [WORD_W-1:0]   word
);
    // Shifter written as a one-hot selection over the offsets.
    always_comb begin
        word = '0;
        for (int k = 0; k < WORD_W; k++) begin
            if (off == OFF_W'(k)) word = pair[2*WORD_W-1-k -: WORD_W];
        end
    end
endmodule

// File: rtl/cwa_boundary_ctrl.sv
// Holds the word boundary offset and the lock flag.
// A comma accepted during search moves the boundary in the same cycle.
// Assumes search is low whenever framing is disabled.
module cwa_boundary_ctrl #(
    parameter int WORD_W = cwa_pkg::CWA_WORD_W,
    localparam int OFF_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             search,
    input  logic             hit,
    input  logic [OFF_W-1:0] hit_off,
    output logic             take,
    output logic [OFF_W-1:0] sel_off,
    output logic             locked
);
    logic [OFF_W-1:0] cur_off;

    // Use the new offset at once when a comma is accepted.
    always_comb begin
        take    = search && hit;
        sel_off = take ? hit_off : cur_off;
    end

    // Remember the boundary and whether a comma has ever set it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_off <= '0;
            locked  <= 1'b0;
        end else if (adv && take) begin
            cur_off <= hit_off;
            locked  <= 1'b1;
        end
    end
endmodule

// File: rtl/comma_word_aligner.sv
// Comma detect word aligner: frames an unaligned 10-bit stream on the positive comma.
// Assumes raw words arrive MSB first; a span needs one earlier valid word.
module comma_word_aligner #(
    parameter int WORD_W = cwa_pkg::CWA_WORD_W,
    parameter int PAT_LEN = cwa_pkg::CWA_PAT_LEN,
    parameter logic [PAT_LEN-1:0] PATTERN = cwa_pkg::CWA_COMMA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] raw_word,
    input  logic              raw_valid,
    input  logic              align_en,
    output logic [WORD_W-1:0] out_word,
    output logic              out_valid,
    output logic              comma_det,
    output logic              locked
);
    localparam int OFF_W = $clog2(WORD_W);

    logic [WORD_W-1:0]   hist;
    logic                hist_full;
    logic [2*WORD_W-1:0] pair;
    logic                hit;
    logic [OFF_W-1:0]    hit_off;
    logic                take;
    logic [OFF_W-1:0]    sel_off;
    logic [WORD_W-1:0]   framed;

    assign pair = {hist, raw_word};

    // Keep the previous valid raw word and note once one exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist      <= '0;
            hist_full <= 1'b0;
        end else if (raw_valid) begin
            hist      <= raw_word;
            hist_full <= 1'b1;
        end
    end

    cwa_comma_scan #(.WORD_W(WORD_W), .PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_scan (
        .pair    (pair),
        .hit     (hit),
        .hit_off (hit_off)
    );

    cwa_boundary_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (raw_valid),
        .search  (align_en && hist_full),
        .hit     (hit),
        .hit_off (hit_off),
        .take    (take),
        .sel_off (sel_off),
        .locked  (locked)
    );

    cwa_window_sel #(.WORD_W(WORD_W)) u_sel (
        .pair (pair),
        .off  (sel_off),
        .word (framed)
    );

    // Register the framed word, its strobe and the comma pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_valid <= 1'b0;
            comma_det <= 1'b0;
        end else begin
            out_valid <= raw_valid;
            comma_det <= raw_valid && take;
            if (raw_valid) out_word <= framed;
        end
    end
endmodule

// File: rtl/cwa_checker.sv
// Temporal checks on the aligner ports, attached by bind.
module cwa_checker #(
    parameter int WORD_W = 10,
    parameter int PAT_LEN = 7,
    parameter logic [PAT_LEN-1:0] PATTERN = 7'b0011111
) (
    input logic              clk,
    input logic              rst_n,
    input logic              raw_valid,
    input logic              align_en,
    input logic [WORD_W-1:0] out_word,
    input logic              out_valid,
    input logic              comma_det,
    input logic              locked
);
    p_det_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        comma_det |-> out_valid);
    p_det_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        comma_det |-> (out_word[WORD_W-1 -: PAT_LEN] == PATTERN));
    p_off_no_det_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !align_en |=> !comma_det);
    p_mode_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        comma_det |-> $past(align_en));
    p_idle_no_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_valid |=> !out_valid);
    p_lock_on_comma_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> comma_det);
    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
endmodule

bind comma_word_aligner cwa_checker #(.WORD_W(WORD_W), .PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_valid (raw_valid),
    .align_en  (align_en),
    .out_word  (out_word),
    .out_valid (out_valid),
    .comma_det (comma_det),
    .locked    (locked)
);

// File: tb/test_comma_word_aligner.sv
module test_comma_word_aligner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] raw_word = '0;
    logic       raw_valid = 1'b0;
    logic       align_en = 1'b0;
    logic [9:0] out_word;
    logic       out_valid;
    logic       comma_det;
    logic       locked;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [9:0] FILL = 10'h2AA;

    always #10 clk = ~clk;

    comma_word_aligner i_comma_word_aligner (
        .clk(clk), .rst_n(rst_n), .raw_word(raw_word), .raw_valid(raw_valid),
        .align_en(align_en), .out_word(out_word), .out_valid(out_valid),
        .comma_det(comma_det), .locked(locked)
    );

    function automatic logic [9:0] win(input logic [9:0] h, input logic [9:0] r, input int k);
        logic [19:0] t;
        t = {h, r} << k;
        return t[19:10];
    endfunction

    // Span of filler with a 10-bit character pat placed at offset k.
    function automatic logic [19:0] span(input logic [9:0] pat, input int k);
        logic [19:0] m;
        m = 20'h003FF << (10 - k);
        return (20'hAAAAA & ~m) | ((20'({pat})) << (10 - k));
    endfunction

    task automatic chk(input string req, input string what, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [9:0] w, input logic v);
        @(negedge clk);
        raw_word  = w;
        raw_valid = v;
        @(posedge clk);
        #5;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        raw_valid = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        chk("R1", "out_valid", 10'(out_valid), 10'd0);
        chk("R1", "comma_det", 10'(comma_det), 10'd0);
        chk("R1", "locked", 10'(locked), 10'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [19:0] s;
        align_en = 1'b1;
        // R2 R4 R5 R9: sweep every offset, with the don't-care tail varied.
        for (int k = 0; k < 10; k++) begin
            do_reset();
            s = span({7'b0011111, 3'(k)}, k);
            drive(FILL, 1'b1);
            drive(s[19:10], 1'b1);
            chk("R4", "no early det", 10'(comma_det), 10'd0);
            chk("R9", "unlocked before comma", 10'(locked), 10'd0);
            drive(s[9:0], 1'b1);
            chk("R4", $sformatf("comma word k=%0d", k), out_word, win(s[19:10], s[9:0], k));
            chk("R4", "det pulse", 10'(comma_det), 10'd1);
            chk("R9", "locked", 10'(locked), 10'd1);
            drive(FILL, 1'b1);
            chk("R5", $sformatf("next word k=%0d", k), out_word, win(s[9:0], FILL, k));
            chk("R2", "single pulse", 10'(comma_det), 10'd0);
        end

        // R8: idle cycle holds output and strobe drops.
        drive(10'h155, 1'b0);
        chk("R8", "valid low", 10'(out_valid), 10'd0);
        chk("R8", "word held", out_word, win(span({7'b0011111, 3'd1}, 9)[9:0], FILL, 9));
        drive(10'h155, 1'b1);
        chk("R8", "valid back", 10'(out_valid), 10'd1);

        // R3: inverted comma does not frame.
        do_reset();
        s = span({7'b1100000, 3'b101}, 3);
        drive(FILL, 1'b1);
        drive(s[19:10], 1'b1);
        drive(s[9:0], 1'b1);
        chk("R3", "no det", 10'(comma_det), 10'd0);
        chk("R3", "boundary 0", out_word, s[19:10]);
        chk("R3", "unlocked", 10'(locked), 10'd0);

        // R6 R7: lock at 4, then disable framing.
        do_reset();
        s = span({7'b0011111, 3'b000}, 4);
        drive(FILL, 1'b1);
        drive(s[19:10], 1'b1);
        drive(s[9:0], 1'b1);
        chk("R4", "lock at 4", 10'(comma_det), 10'd1);
        @(negedge clk);
        align_en = 1'b0;
        s = span({7'b0011111, 3'b011}, 4);
        drive(s[19:10], 1'b1);
        drive(s[9:0], 1'b1);
        chk("R7", "no det at held boundary", 10'(comma_det), 10'd0);
        chk("R7", "word still framed", out_word, win(s[19:10], s[9:0], 4));
        s = span({7'b0011111, 3'b110}, 7);
        drive(s[19:10], 1'b1);
        drive(s[9:0], 1'b1);
        chk("R6", "no det off", 10'(comma_det), 10'd0);
        chk("R6", "boundary kept", out_word, win(s[19:10], s[9:0], 4));
        @(negedge clk);
        align_en = 1'b1;
        drive(s[19:10], 1'b1);
        drive(s[9:0], 1'b1);
        chk("R7", "det back on", 10'(comma_det), 10'd1);
        chk("R4", "moved to 7", out_word, win(s[19:10], s[9:0], 7));

        // R10: commas at offsets 0 and 7 in one span.
        do_reset();
        drive(FILL, 1'b1);
        drive(10'b0011111001, 1'b1);
        drive(10'b1111101010, 1'b1);
        chk("R10", "lowest offset", out_word, 10'b0011111001);
        chk("R10", "det", 10'(comma_det), 10'd1);
        drive(FILL, 1'b1);
        chk("R10", "stays at 0", out_word, 10'b1111101010);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule